// File: doc/BRIEF.md
# Coherent Fan Tachometer Readback with Limit Alert

This block sits between a set of fan period counters and an 8-bit register read/write port. Each counter produces a 16-bit period count together with a one-cycle done strobe. The count grows as the fan slows down. The block shows each count to software as two byte registers and keeps the pair consistent: reading the low byte locks the channel, so the high byte returned afterwards belongs to the same measurement even if the counter finishes again in between. Results that arrive while a channel is locked go into a per-channel holding register. They become visible as soon as software completes the pair by reading the high byte.

Each channel also has a 16-bit slowest-allowed limit. Software writes this limit one byte at a time. Every new result from an armed channel is compared with its limit. A count above the limit, even by one, sets a sticky status bit. Software clears the status bits by reading the status register. An active-low alert output reports any status bit that is not masked.

After reset, every channel starts locked and unarmed. No result reaches the visible registers and no status bit can be set for a channel until software has read that channel's high byte once.

Top module: `tach_coherent_rb`

## Requirements
- R1: After reset, every result byte reads 0x00, every limit byte reads 0xFF, the status register and the mask register read 0x00, `fan_stat` is 0 and `alert_n` is 1.
- R2: Channel i's result is mapped at `RES_BASE+2i` (low byte, bits 7:0) and `RES_BASE+2i+1` (high byte, bits 15:8), with defaults 0x28..0x2F for four channels. Any address that is not mapped reads 0x00.
- R3: Reading a channel's low byte locks that channel. Until its high byte is read, the visible 16-bit value does not change. This holds even for a done strobe that arrives in the same cycle as the low-byte read.
- R4: Reading the high byte of a locked channel unlocks it. If a result arrived while the channel was locked, the most recent such result becomes visible on the next cycle.
- R5: Every channel is locked at reset. Results arriving before the channel's first high-byte read are not visible until that read has happened.
- R6: A channel's status bit stays 0, whatever results arrive, until that channel's high byte has been read once.
- R7: For an armed channel, a done strobe with a result strictly greater than the channel's limit sets status bit i on the next cycle. A result equal to the limit, or below it, does not set the bit.
- R8: Status bits are sticky. A read of `STAT_ADDR` (default 0x42) returns bit i = channel i and clears all bits. If a bit is set in the same cycle as the clearing read, the bit ends up set.
- R9: `alert_n` is low exactly when some status bit i is 1 while bit i of the mask register is 0. The mask register is at `MASK_ADDR` (default 0x74), can be written and read back, and a mask bit of 1 hides that channel from the alert.
- R10: Channel i's limit is at `LIM_BASE+2i` (low byte) and `LIM_BASE+2i+1` (high byte), with default base 0x54. A write updates only that byte, and the limit reads back. Writes to result or unmapped addresses change nothing.
- R11: Read data is registered. It appears on `reg_rdata` on the cycle after `reg_re` is sampled, and holds until the next read.
- R12: While a channel is unlocked, each done strobe makes its result visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW (8) | Register byte address |
| reg_wdata | input | DW (8) | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DW (8) | Registered read data |
| meas_val | input | NCH*2*DW (64) | Period counts, channel i in bits [16i+15:16i] |
| meas_done | input | NCH (4) | One-cycle strobe per channel, new count valid |
| fan_stat | output | NCH (4) | Sticky over-limit status bits |
| alert_n | output | 1 | Active-low alert for unmasked status |

## Verification
The bench runs a done strobe in the same cycle as a low-byte read. A design that updated the visible value in that cycle would return a high byte from the newer count. It feeds results into channels that were never read and programs a limit below those results. A design that ignored the power-up lock would show the results or raise an alert. It tests a result equal to the limit and one count above it, to catch an off-by-one comparison. It also sets a status bit in the same cycle as a status read, where a design that lets the clear win would lose the event. It checks that the high byte stays frozen across several strobes and that the most recent held result, not the first, appears after unlock.

// File: rtl/tach_rb_pkg.sv
package tach_rb_pkg;

   typedef enum logic [2:0] {
      ACC_NONE   = 3'd0,
      ACC_RES_LO = 3'd1,
      ACC_RES_HI = 3'd2,
      ACC_LIM_LO = 3'd3,
      ACC_LIM_HI = 3'd4,
      ACC_STAT   = 3'd5,
      ACC_MASK   = 3'd6
   } acc_t;

endpackage

// File: rtl/tach_addr_dec.sv
module tach_addr_dec
   import tach_rb_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int AW        = 8,
   parameter int RES_BASE  = 'h28,
   parameter int LIM_BASE  = 'h54,
   parameter int STAT_ADDR = 'h42,
   parameter int MASK_ADDR = 'h74,
   localparam int CW       = $clog2(NCH)
) (
   input  logic [AW-1:0] addr,
   output acc_t          kind,
   output logic [CW-1:0] ch
);

   always_comb begin
      kind = ACC_NONE;
      ch   = '0;
      if (addr == AW'(STAT_ADDR)) kind = ACC_STAT;
      if (addr == AW'(MASK_ADDR)) kind = ACC_MASK;
      for (int i = 0; i < NCH; i++) begin
         if (addr == AW'(RES_BASE + 2*i)) begin
            kind = ACC_RES_LO; ch = CW'(i);
         end
         if (addr == AW'(RES_BASE + 2*i + 1)) begin
            kind = ACC_RES_HI; ch = CW'(i);
         end
         if (addr == AW'(LIM_BASE + 2*i)) begin
            kind = ACC_LIM_LO; ch = CW'(i);
         end
         if (addr == AW'(LIM_BASE + 2*i + 1)) begin
            kind = ACC_LIM_HI; ch = CW'(i);
         end
      end
   end

endmodule

// File: rtl/tach_chan.sv
module tach_chan #(
   parameter int DW  = 8,
   localparam int VW = 2*DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic [VW-1:0] res,
   input  logic          rd_lo,
   input  logic          rd_hi,
   input  logic [VW-1:0] lim,
   output logic [VW-1:0] vis,
   output logic          locked,
   output logic          armed,
   output logic          over
);

   logic [VW-1:0] pend_q;
   logic          pend_v;
   logic          unlock;

   assign unlock = rd_hi && locked;
   assign over   = done && armed && (res > lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
         armed  <= 1'b0;
      end else if (rd_lo) begin
         locked <= 1'b1;
      end else if (rd_hi) begin
         locked <= 1'b0;
         armed  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vis    <= '0;
         pend_q <= '0;
         pend_v <= 1'b0;
      end else if (unlock) begin
         if (done)        vis <= res;
         else if (pend_v) vis <= pend_q;
         pend_v <= 1'b0;
      end else if (done) begin
         if (!locked && !rd_lo) begin
            vis <= res;
         end else begin
            pend_q <= res;
            pend_v <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tach_coherent_rb.sv
module tach_coherent_rb
   import tach_rb_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int DW        = 8,
   parameter int AW        = 8,
   parameter int RES_BASE  = 'h28,
   parameter int LIM_BASE  = 'h54,
   parameter int STAT_ADDR = 'h42,
   parameter int MASK_ADDR = 'h74,
   localparam int VW       = 2*DW,
   localparam int CW       = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [DW-1:0]     reg_rdata,
   input  logic [NCH*VW-1:0] meas_val,
   input  logic [NCH-1:0]    meas_done,
   output logic [NCH-1:0]    fan_stat,
   output logic              alert_n
);

   if (NCH < 2 || NCH > DW) begin : g_bad_nch
      $error("NCH must lie between 2 and DW");
   end
   if (!(LIM_BASE >= RES_BASE + 2*NCH || RES_BASE >= LIM_BASE + 2*NCH)) begin : g_bad_map
      $error("result and limit windows overlap");
   end
   if (RES_BASE + 2*NCH > (1 << AW) || LIM_BASE + 2*NCH > (1 << AW)) begin : g_bad_aw
      $error("register windows exceed address space");
   end

   acc_t              acc_kind;
   logic [CW-1:0]     acc_ch;
   logic [NCH-1:0]    rd_lo_v, rd_hi_v, locked_v, armed_v, over_v;
   logic [NCH-1:0]    stat_q, mask_q;
   logic [VW-1:0]     lim_q [NCH];
   logic [VW-1:0]     vis_a [NCH];
   logic [NCH*VW-1:0] vis_flat;
   logic              stat_rd;

   tach_addr_dec #(
      .NCH(NCH), .AW(AW), .RES_BASE(RES_BASE), .LIM_BASE(LIM_BASE),
      .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_dec (
      .addr (reg_addr),
      .kind (acc_kind),
      .ch   (acc_ch)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign rd_lo_v[i] = reg_re && acc_kind == ACC_RES_LO && acc_ch == CW'(i);
      assign rd_hi_v[i] = reg_re && acc_kind == ACC_RES_HI && acc_ch == CW'(i);
      assign vis_flat[i*VW +: VW] = vis_a[i];

      tach_chan #(.DW(DW)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .done   (meas_done[i]),
         .res    (meas_val[i*VW +: VW]),
         .rd_lo  (rd_lo_v[i]),
         .rd_hi  (rd_hi_v[i]),
         .lim    (lim_q[i]),
         .vis    (vis_a[i]),
         .locked (locked_v[i]),
         .armed  (armed_v[i]),
         .over   (over_v[i])
      );
   end

   assign stat_rd  = reg_re && acc_kind == ACC_STAT;
   assign fan_stat = stat_q;
   assign alert_n  = ~|(stat_q & ~mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) lim_q[i] <= '1;
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (reg_we) begin
            case (acc_kind)
               ACC_LIM_LO: lim_q[acc_ch][DW-1:0]  <= reg_wdata;
               ACC_LIM_HI: lim_q[acc_ch][VW-1:DW] <= reg_wdata;
               ACC_MASK:   mask_q <= reg_wdata[NCH-1:0];
               default: ;
            endcase
         end
         stat_q <= (stat_rd ? '0 : stat_q) | over_v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_re) begin
         case (acc_kind)
            ACC_RES_LO: reg_rdata <= vis_a[acc_ch][DW-1:0];
            ACC_RES_HI: reg_rdata <= vis_a[acc_ch][VW-1:DW];
            ACC_LIM_LO: reg_rdata <= lim_q[acc_ch][DW-1:0];
            ACC_LIM_HI: reg_rdata <= lim_q[acc_ch][VW-1:DW];
            ACC_STAT:   reg_rdata <= DW'(stat_q);
            ACC_MASK:   reg_rdata <= DW'(mask_q);
            default:    reg_rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/tach_coherent_rb_chk.sv
module tach_coherent_rb_chk
   import tach_rb_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 8,
   localparam int VW = 2*DW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_re,
   input acc_t              acc_kind,
   input logic [NCH-1:0]    meas_done,
   input logic [NCH-1:0]    fan_stat,
   input logic              alert_n,
   input logic [NCH-1:0]    mask_q,
   input logic [NCH-1:0]    locked_v,
   input logic [NCH-1:0]    armed_v,
   input logic [NCH-1:0]    rd_hi_v,
   input logic [NCH*VW-1:0] vis_flat
);

   logic stat_rd;
   assign stat_rd = reg_re && acc_kind == ACC_STAT;

   for (genvar i = 0; i < NCH; i++) begin : g_a
      // R3: a locked channel's visible value holds until its high byte is read
      p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
         locked_v[i] && !rd_hi_v[i] |=> $stable(vis_flat[i*VW +: VW]));
      // R4: high-byte read of a locked channel unlocks it
      p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hi_v[i] && locked_v[i] |=> !locked_v[i]);
      // R6: no status before arming
      p_quiet_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !armed_v[i] |-> !fan_stat[i]);
      // R8: status holds until a status read
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         fan_stat[i] && !stat_rd |=> fan_stat[i]);
      // R9: unmasked status pulls the alert low
      p_alert_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
         fan_stat[i] && !mask_q[i] |-> !alert_n);
   end

   // R8: a status read with no new event clears every bit
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd && meas_done == '0 |=> fan_stat == '0);
   // R9: no status means no alert
   p_idle_alert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fan_stat == '0 |-> alert_n);

endmodule

bind tach_coherent_rb tach_coherent_rb_chk #(.NCH(NCH), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_re    (reg_re),
   .acc_kind  (acc_kind),
   .meas_done (meas_done),
   .fan_stat  (fan_stat),
   .alert_n   (alert_n),
   .mask_q    (mask_q),
   .locked_v  (locked_v),
   .armed_v   (armed_v),
   .rd_hi_v   (rd_hi_v),
   .vis_flat  (vis_flat)
);

// File: tb/tach_coherent_rb_bench.sv
module tach_coherent_rb_bench;

   localparam int NCH = 4;
   localparam int DW  = 8;
   localparam int VW  = 16;
   localparam logic [7:0] STAT_A = 8'h42;
   localparam logic [7:0] MASK_A = 8'h74;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        reg_addr = '0;
   logic [7:0]        reg_wdata = '0;
   logic              reg_we = 1'b0;
   logic              reg_re = 1'b0;
   logic [7:0]        reg_rdata;
   logic [NCH*VW-1:0] meas_val = '0;
   logic [NCH-1:0]    meas_done = '0;
   logic [NCH-1:0]    fan_stat;
   logic              alert_n;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       re_seen = 1'b0;

   always #5 clk = ~clk;

   tach_coherent_rb u_tach_coherent_rb (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
      .meas_val(meas_val), .meas_done(meas_done),
      .fan_stat(fan_stat), .alert_n(alert_n)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // driver: issue a read and push the expected byte
   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse(input int ch, input logic [15:0] v);
      @(negedge clk);
      meas_val[ch*VW +: VW] = v; meas_done[ch] = 1'b1;
      @(negedge clk);
      meas_done = '0;
   endtask

   // read and done strobe in the same cycle
   task automatic rd_pulse(input logic [7:0] a, input logic [7:0] exp, input string tag,
                           input int ch, input logic [15:0] v);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      meas_val[ch*VW +: VW] = v; meas_done[ch] = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      reg_re = 1'b0; meas_done = '0;
   endtask

   always @(posedge clk) re_seen <= reg_re;

   // monitor: R11 read data is valid on the cycle after the strobe
   always @(negedge clk) begin
      if (re_seen) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R11 unexpected read data actual %02h expected none", reg_rdata);
         end else begin
            check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check({4'h0, fan_stat}, 8'h00, "R1 fan_stat");
      check({7'h0, alert_n}, 8'h01, "R1 alert_n");
      rd(8'h28, 8'h00, "R1 result");
      rd(8'h54, 8'hFF, "R1 limit lo");
      rd(8'h5B, 8'hFF, "R1 limit hi ch3");
      rd(STAT_A, 8'h00, "R1 status");
      rd(MASK_A, 8'h00, "R1 mask");
      // R5 power-up lock, R6 suppression
      wr(8'h56, 8'h00); wr(8'h57, 8'h01);
      pulse(0, 16'h1234);
      pulse(1, 16'h2000);
      check({4'h0, fan_stat}, 8'h00, "R6 unarmed no status");
      check({7'h0, alert_n}, 8'h01, "R6 unarmed no alert");
      rd(8'h28, 8'h00, "R5 locked lo");
      rd(8'h29, 8'h00, "R5 locked hi");
      rd(8'h28, 8'h34, "R4 copied lo");
      rd(8'h29, 8'h12, "R4 copied hi");
      // R12 unlocked update, R2 map for other channels
      pulse(0, 16'h0ABC);
      rd(8'h28, 8'hBC, "R12 lo");
      rd(8'h29, 8'h0A, "R12 hi");
      rd(8'h2D, 8'h00, "R2 ch2 arm");
      pulse(2, 16'h5566);
      rd(8'h2C, 8'h66, "R2 ch2 lo");
      rd(8'h2D, 8'h55, "R2 ch2 hi");
      rd(8'h2F, 8'h00, "R2 ch3 arm");
      pulse(3, 16'h7788);
      rd(8'h2E, 8'h88, "R2 ch3 lo");
      rd(8'h2F, 8'h77, "R11/R2 ch3 hi");
      rd(8'h10, 8'h00, "R2 unmapped");
      // R3 freeze across strobes, R4 latest wins
      rd(8'h28, 8'hBC, "R3 lock lo");
      pulse(0, 16'h1111);
      pulse(0, 16'h2222);
      rd(8'h29, 8'h0A, "R3 frozen hi");
      rd(8'h28, 8'h22, "R4 latest lo");
      rd(8'h29, 8'h22, "R4 latest hi");
      // R3 strobe in the same cycle as the low read
      rd_pulse(8'h28, 8'h22, "R3 same-cycle lo", 0, 16'h3333);
      rd(8'h29, 8'h22, "R3 same-cycle hi frozen");
      rd(8'h28, 8'h33, "R4 after same-cycle lo");
      rd(8'h29, 8'h33, "R4 after same-cycle hi");
      // R10 limit write and readback, R7 compare
      wr(8'h54, 8'h00); wr(8'h55, 8'h10);
      rd(8'h54, 8'h00, "R10 limit lo");
      rd(8'h55, 8'h10, "R10 limit hi");
      rd(8'h57, 8'h01, "R10 ch1 limit hi");
      pulse(0, 16'h1000);
      check({4'h0, fan_stat}, 8'h00, "R7 equal no status");
      check({7'h0, alert_n}, 8'h01, "R7 equal no alert");
      pulse(0, 16'h1001);
      check({4'h0, fan_stat}, 8'h01, "R7 over by one");
      check({7'h0, alert_n}, 8'h00, "R9 alert low");
      // R8 sticky, clear on read
      pulse(0, 16'h0500);
      check({4'h0, fan_stat}, 8'h01, "R8 sticky");
      rd(STAT_A, 8'h01, "R8 status read");
      check({4'h0, fan_stat}, 8'h00, "R8 cleared");
      check({7'h0, alert_n}, 8'h01, "R8 alert released");
      rd(STAT_A, 8'h00, "R8 status empty");
      // R9 mask
      wr(MASK_A, 8'h01);
      pulse(0, 16'h2000);
      check({4'h0, fan_stat}, 8'h01, "R9 masked status");
      check({7'h0, alert_n}, 8'h01, "R9 masked alert");
      wr(MASK_A, 8'h00);
      check({7'h0, alert_n}, 8'h00, "R9 unmasked alert");
      rd(MASK_A, 8'h00, "R9 mask readback");
      rd(STAT_A, 8'h01, "R8 clear before race");
      // R8 set wins over clear
      rd_pulse(STAT_A, 8'h00, "R8 race read", 0, 16'h2000);
      check({4'h0, fan_stat}, 8'h01, "R8 set wins");
      rd(STAT_A, 8'h01, "R8 race status");
      // R10 write to a result register is ignored
      wr(8'h28, 8'h99);
      rd(8'h28, 8'h00, "R10 result not writable lo");
      rd(8'h29, 8'h20, "R10 result not writable hi");
      // R6 arming channel 1 enables its status
      rd(8'h2B, 8'h00, "R6 ch1 arm");
      pulse(1, 16'h2000);
      check({4'h0, fan_stat}, 8'h02, "R6 ch1 armed status");
      rd(8'h2A, 8'h00, "R12 ch1 lo");
      rd(8'h2B, 8'h20, "R12 ch1 hi");
      rd(STAT_A, 8'h02, "R8 ch1 status");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R11 reads pending actual %0d expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule